// File: doc/BRIEF.md
# Multichannel ADC Command Interface

This block is the device-side control logic of a sampling analog-to-digital converter that is driven over a four-wire SPI link. A host sends one 16-bit command per chip-select window. The block decodes the command's mode code, picks the channel to convert next, and keeps two configuration registers. One holds the conversion settings: GPIO output levels, a GPIO-readback flag, power-down and input range. The other holds the GPIO configuration: pin directions, alarm mode, and which pins act as range and power-down inputs. Each response word carries a channel tag in its top nibble and the left-justified conversion result below it.

A channel requested in frame N is presented on `samp_ch_o` while frame N+1 runs. The value on `samp_data_i` is captured when frame N+1 closes, and it is shifted out during frame N+2. The analog conversion itself sits outside the block: an external converter model watches `samp_ch_o` and drives `samp_data_i`. All SPI inputs are taken to be synchronous to `clk_i`, which runs several times faster than SCLK. The block detects SCLK and chip-select edges by comparing each input with its value one clock earlier.

Top module: `adc_cmd_if`

## Requirements
- R1: After reset, `gpio_o`, `gpio_oe_o`, `alarm_mode_o`, `range_hi_o`, `pwr_down_o` and `samp_ch_o` are zero, and the first two 16-bit response frames after reset read 0x0000.
- R2: A frame counts only if it has exactly 16 rising SCLK edges between the falling and the rising edge of `cs_ni`. Any other frame changes no configuration output, no `samp_ch_o` value and no later response.
- R3: A frame whose bits 15:12 equal 4'b0001 (manual) loads bits 10:7 as the channel. `samp_ch_o` shows it from the close of that frame.
- R4: In a manual frame, the settings (bits 6:0) are loaded only when bit 11 is 1, and are otherwise kept. Bits 3:0 drive `gpio_o`, bit 5 drives `pwr_down_o` and bit 6 drives `range_hi_o`.
- R5: A frame whose bits 15:12 equal 4'b0100 (GPIO configuration) loads bits 3:0 into `gpio_oe_o` (1 = output) and bits 6:4 into `alarm_mode_o`.
- R6: A GPIO configuration frame with bit 9 set clears both configuration registers and the result pipeline. `samp_ch_o` returns to 0, and the next two responses read 0x0000.
- R7: The response in frame N+2 is {channel requested in frame N, result}, where the result is the `samp_data_i` value captured at the close of frame N+1, while `samp_ch_o` showed that channel.
- R8: The result sits in bits 11:0 left-justified: shifted up by 12-RES_W, with the low 12-RES_W bits zero.
- R9: While settings bit 4 is 1, response bits 15:12 carry `gpio_i` as sampled when `cs_ni` falls, in place of the channel tag. This applies from the frame after the one that set the bit.
- R10: `miso_o` presents response bit 15 once `cs_ni` falls and advances one bit per falling SCLK edge. `mosi_i` is sampled on rising SCLK edges, MSB first. `miso_o` is 0 while `cs_ni` is high.
- R11: With GPIO configuration bit 7 set, `range_hi_o` follows `gpio_i[2]`. With bit 8 set, `pwr_down_o` is settings bit 5 OR `gpio_i[3]`.
- R12: A valid frame with any other mode code leaves both configuration registers and `samp_ch_o` unchanged, but still advances the result pipeline.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Block clock, oversamples the SPI lines |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cs_ni | input | 1 | Frame select, active low |
| sclk_i | input | 1 | Serial clock, idles low |
| mosi_i | input | 1 | Command data in |
| miso_o | output | 1 | Response data out |
| gpio_i | input | 4 | GPIO pin input levels |
| gpio_o | output | 4 | GPIO output levels |
| gpio_oe_o | output | 4 | GPIO output enables |
| range_hi_o | output | 1 | Doubled input range selected |
| pwr_down_o | output | 1 | Power-down request |
| alarm_mode_o | output | 3 | Alarm mode configuration |
| samp_ch_o | output | 4 | Channel under conversion |
| samp_data_i | input | RES_W | Conversion result for `samp_ch_o` |

## Verification
The closing edge of one frame updates the settings register and the result pipeline together. A manual frame that both requests a channel and sets the GPIO-readback flag must therefore produce, one frame later, the `gpio_i` nibble over the data captured for the earlier channel. The next frame must then return the newly requested channel's data. The bench provokes this coincidence on purpose, and also sends a clear command while a result is in flight. Each response is compared with a reference model that the bench advances only on well-formed 16-edge frames, using a 10-bit result width so that the left-justification shift is visible.

// File: rtl/adc_cmd_pkg.sv
package adc_cmd_pkg;
  localparam int FRAME_W  = 16;
  localparam int GPIO_N   = 4;
  localparam int CH_W     = 4;
  localparam int DATA_W   = FRAME_W - CH_W;
  localparam int ALARM_W  = 3;
  localparam int PAYLD_W  = 10;
  localparam int MODE_LSB = 12;
  localparam int WE_BIT   = 11;
  localparam int CH_LSB   = 7;
  localparam int CLR_BIT  = 9;

  localparam logic [3:0] MODE_MAN  = 4'b0001;
  localparam logic [3:0] MODE_GPIO = 4'b0100;

  typedef struct packed {
    logic              range_hi;
    logic              pwr_dn;
    logic              gpio_rd;
    logic [GPIO_N-1:0] gpio_lvl;
  } conv_set_t;

  typedef struct packed {
    logic               pd_pin;
    logic               range_pin;
    logic [ALARM_W-1:0] alarm;
    logic [GPIO_N-1:0]  dir;
  } gpio_cfg_t;

  localparam int SET_W = $bits(conv_set_t);
  localparam int CFG_W = $bits(gpio_cfg_t);
endpackage

// File: rtl/adc_cmd_rx.sv
module adc_cmd_rx import adc_cmd_pkg::*; (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               cs_ni,
  input  logic               sclk_i,
  input  logic               mosi_i,
  output logic               frame_start_o,
  output logic               frame_ok_o,
  output logic               sclk_fall_o,
  output logic [FRAME_W-1:0] word_o
);
  localparam int CNT_W = $clog2(FRAME_W + 2);
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(FRAME_W);
  localparam logic [CNT_W-1:0] CNT_SAT  = CNT_W'(FRAME_W + 1);

  logic             sclk_q, cs_q;
  logic [CNT_W-1:0] cnt_q;
  logic [FRAME_W-1:0] sh_q;
  logic             rise;

  assign rise          = ~cs_ni & sclk_i & ~sclk_q;
  assign sclk_fall_o   = ~cs_ni & ~sclk_i & sclk_q;
  assign frame_start_o = cs_q & ~cs_ni;
  assign frame_ok_o    = ~cs_q & cs_ni & (cnt_q == CNT_FULL);
  assign word_o        = sh_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sclk_q <= 1'b0;
      cs_q   <= 1'b1;
      cnt_q  <= '0;
      sh_q   <= '0;
    end else begin
      sclk_q <= sclk_i;
      cs_q   <= cs_ni;
      if (frame_start_o) begin
        cnt_q <= '0;
      end else if (rise) begin
        sh_q <= {sh_q[FRAME_W-2:0], mosi_i};
        if (cnt_q != CNT_SAT) cnt_q <= cnt_q + 1'b1;
      end
    end
  end
endmodule

// File: rtl/adc_cmd_regs.sv
module adc_cmd_regs import adc_cmd_pkg::*; (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               frame_ok_i,
  input  logic [3:0]         mode_i,
  input  logic               we_i,
  input  logic [PAYLD_W-1:0] payld_i,
  output logic               man_o,
  output logic               clr_o,
  output conv_set_t          set_o,
  output gpio_cfg_t          cfg_o
);
  logic gpio_cmd;

  assign man_o    = (mode_i == MODE_MAN);
  assign gpio_cmd = (mode_i == MODE_GPIO);
  assign clr_o    = frame_ok_i & gpio_cmd & payld_i[CLR_BIT];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      set_o <= '0;
      cfg_o <= '0;
    end else if (clr_o) begin
      set_o <= '0;
      cfg_o <= '0;
    end else if (frame_ok_i) begin
      if (man_o && we_i) set_o <= conv_set_t'(payld_i[SET_W-1:0]);
      if (gpio_cmd)      cfg_o <= gpio_cfg_t'(payld_i[CFG_W-1:0]);
    end
  end
endmodule

// File: rtl/adc_cmd_pipe.sv
module adc_cmd_pipe import adc_cmd_pkg::*; #(
  parameter int RES_W = 12
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              frame_ok_i,
  input  logic              clr_i,
  input  logic              man_i,
  input  logic [CH_W-1:0]   req_ch_i,
  input  logic [RES_W-1:0]  samp_data_i,
  output logic [CH_W-1:0]   conv_ch_o,
  output logic [CH_W-1:0]   out_ch_o,
  output logic [DATA_W-1:0] out_dat_o
);
  localparam int SHIFT = DATA_W - RES_W;

  logic             vld_q;
  logic [RES_W-1:0] res_q;

  generate
    if (SHIFT > 0) begin : g_pad
      assign out_dat_o = {res_q, {SHIFT{1'b0}}};
    end else begin : g_full
      assign out_dat_o = res_q;
    end
  endgenerate

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_q     <= 1'b0;
      conv_ch_o <= '0;
      out_ch_o  <= '0;
      res_q     <= '0;
    end else if (clr_i) begin
      vld_q     <= 1'b0;
      conv_ch_o <= '0;
      out_ch_o  <= '0;
      res_q     <= '0;
    end else if (frame_ok_i) begin
      vld_q    <= 1'b1;
      out_ch_o <= vld_q ? conv_ch_o : '0;
      res_q    <= vld_q ? samp_data_i : '0;
      if (man_i) conv_ch_o <= req_ch_i;
    end
  end
endmodule

// File: rtl/adc_cmd_tx.sv
module adc_cmd_tx import adc_cmd_pkg::*; (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               cs_ni,
  input  logic               frame_start_i,
  input  logic               sclk_fall_i,
  input  logic [FRAME_W-1:0] resp_i,
  output logic               miso_o
);
  logic [FRAME_W-1:0] sh_q;

  assign miso_o = ~cs_ni & sh_q[FRAME_W-1];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            sh_q <= '0;
    else if (frame_start_i) sh_q <= resp_i;
    else if (sclk_fall_i)   sh_q <= {sh_q[FRAME_W-2:0], 1'b0};
  end
endmodule

// File: rtl/adc_cmd_if.sv
module adc_cmd_if import adc_cmd_pkg::*; #(
  parameter int RES_W = 12
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               cs_ni,
  input  logic               sclk_i,
  input  logic               mosi_i,
  output logic               miso_o,
  input  logic [GPIO_N-1:0]  gpio_i,
  output logic [GPIO_N-1:0]  gpio_o,
  output logic [GPIO_N-1:0]  gpio_oe_o,
  output logic               range_hi_o,
  output logic               pwr_down_o,
  output logic [ALARM_W-1:0] alarm_mode_o,
  output logic [CH_W-1:0]    samp_ch_o,
  input  logic [RES_W-1:0]   samp_data_i
);
  logic               frame_start, frame_ok, sclk_fall, man, clr;
  logic [FRAME_W-1:0] word, resp;
  logic [CH_W-1:0]    out_ch;
  logic [DATA_W-1:0]  out_dat;
  conv_set_t          set_q;
  gpio_cfg_t          cfg_q;

  adc_cmd_rx i_rx (
    .clk_i, .rst_ni, .cs_ni, .sclk_i, .mosi_i,
    .frame_start_o (frame_start),
    .frame_ok_o    (frame_ok),
    .sclk_fall_o   (sclk_fall),
    .word_o        (word)
  );

  adc_cmd_regs i_regs (
    .clk_i, .rst_ni,
    .frame_ok_i (frame_ok),
    .mode_i     (word[FRAME_W-1:MODE_LSB]),
    .we_i       (word[WE_BIT]),
    .payld_i    (word[PAYLD_W-1:0]),
    .man_o      (man),
    .clr_o      (clr),
    .set_o      (set_q),
    .cfg_o      (cfg_q)
  );

  adc_cmd_pipe #(.RES_W(RES_W)) i_pipe (
    .clk_i, .rst_ni,
    .frame_ok_i  (frame_ok),
    .clr_i       (clr),
    .man_i       (man),
    .req_ch_i    (word[CH_LSB +: CH_W]),
    .samp_data_i (samp_data_i),
    .conv_ch_o   (samp_ch_o),
    .out_ch_o    (out_ch),
    .out_dat_o   (out_dat)
  );

  // top nibble is either the result's channel or live GPIO levels
  assign resp = {set_q.gpio_rd ? gpio_i : out_ch, out_dat};

  adc_cmd_tx i_tx (
    .clk_i, .rst_ni, .cs_ni,
    .frame_start_i (frame_start),
    .sclk_fall_i   (sclk_fall),
    .resp_i        (resp),
    .miso_o        (miso_o)
  );

  assign gpio_o       = set_q.gpio_lvl;
  assign gpio_oe_o    = cfg_q.dir;
  assign alarm_mode_o = cfg_q.alarm;
  assign range_hi_o   = cfg_q.range_pin ? gpio_i[2] : set_q.range_hi;
  assign pwr_down_o   = set_q.pwr_dn | (cfg_q.pd_pin & gpio_i[3]);
endmodule

// File: rtl/adc_cmd_if_chk.sv
module adc_cmd_if_chk import adc_cmd_pkg::*; (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               cs_ni,
  input logic               sclk_i,
  input logic               miso_o,
  input logic [GPIO_N-1:0]  gpio_o,
  input logic [GPIO_N-1:0]  gpio_oe_o,
  input logic [ALARM_W-1:0] alarm_mode_o,
  input logic [CH_W-1:0]    samp_ch_o
);
  // R10: line quiet outside a frame
  p_miso_idle_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cs_ni |-> !miso_o);

  // R10: data moves only after a falling SCLK or the frame opening
  p_miso_hold_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cs_ni && !$fell(sclk_i) && !$fell(cs_ni)) |=> (cs_ni || $stable(miso_o)));

  // R3: channel under conversion changes only when a frame closes
  p_ch_hold_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$rose(cs_ni) |=> $stable(samp_ch_o));

  // R4: settings outputs change only when a frame closes
  p_set_hold_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$rose(cs_ni) |=> $stable(gpio_o));

  // R5: GPIO configuration changes only when a frame closes
  p_cfg_hold_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$rose(cs_ni) |=> $stable({gpio_oe_o, alarm_mode_o}));
endmodule

bind adc_cmd_if adc_cmd_if_chk i_chk (.*);

// File: tb/test_adc_cmd_if.sv
module test_adc_cmd_if;
  localparam int RW = 10;

  logic clk = 1'b0;
  logic rst_n, cs_n, sclk, mosi, miso;
  logic [3:0] gpio_in, gpio_out, gpio_oe, samp_ch;
  logic [2:0] alarm;
  logic range_hi, pwr_dn;
  logic [RW-1:0] samp_data, salt;

  int checks = 0, errs = 0;
  bit done = 0;

  logic       m_vld;
  logic [3:0] m_conv, m_out_ch;
  logic [RW-1:0] m_out_dat;
  logic [6:0] m_set;
  logic [8:0] m_cfg;

  always #2 clk = ~clk;

  function automatic logic [RW-1:0] fdat(input logic [3:0] ch);
    return RW'((32'(ch) * 71 + 13) % 1024) ^ salt;
  endfunction

  always_comb samp_data = fdat(samp_ch);

  adc_cmd_if #(.RES_W(RW)) i_adc_cmd_if (
    .clk_i(clk), .rst_ni(rst_n), .cs_ni(cs_n), .sclk_i(sclk), .mosi_i(mosi),
    .miso_o(miso), .gpio_i(gpio_in), .gpio_o(gpio_out), .gpio_oe_o(gpio_oe),
    .range_hi_o(range_hi), .pwr_down_o(pwr_dn), .alarm_mode_o(alarm),
    .samp_ch_o(samp_ch), .samp_data_i(samp_data)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic spi_frame(input logic [15:0] w, input int nbits, output logic [15:0] r);
    r = '0;
    @(negedge clk) cs_n = 1'b0;
    repeat (3) @(negedge clk);
    for (int i = 0; i < nbits; i++) begin
      mosi = (i < 16) ? w[15-i] : 1'b0;
      repeat (2) @(negedge clk);
      if (i < 16) r[15-i] = miso;
      sclk = 1'b1;
      repeat (4) @(negedge clk);
      sclk = 1'b0;
      repeat (2) @(negedge clk);
    end
    repeat (2) @(negedge clk);
    cs_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  task automatic model_commit(input logic [15:0] w);
    if (w[15:12] == 4'b0100 && w[9]) begin
      m_vld = 0; m_conv = 0; m_out_ch = 0; m_out_dat = 0; m_set = 0; m_cfg = 0;
    end else begin
      m_out_ch  = m_vld ? m_conv : 4'h0;
      m_out_dat = m_vld ? fdat(m_conv) : '0;
      m_vld     = 1;
      if (w[15:12] == 4'b0001) begin
        m_conv = w[10:7];
        if (w[11]) m_set = w[6:0];
      end
      if (w[15:12] == 4'b0100) m_cfg = w[8:0];
    end
  endtask

  task automatic chk_cfg(input string tag);
    chk({tag, " gpio_o"}, 32'(gpio_out), 32'(m_set[3:0]));
    chk({tag, " oe"}, 32'(gpio_oe), 32'(m_cfg[3:0]));
    chk({tag, " alarm"}, 32'(alarm), 32'(m_cfg[6:4]));
    chk({tag, " range"}, 32'(range_hi), 32'(m_cfg[7] ? gpio_in[2] : m_set[6]));
    chk({tag, " pd"}, 32'(pwr_dn), 32'(m_set[5] | (m_cfg[8] & gpio_in[3])));
    chk({tag, " samp_ch"}, 32'(samp_ch), 32'(m_conv));
  endtask

  task automatic xfer(input string tag, input logic [15:0] w);
    logic [15:0] r, exp;
    exp = {m_set[4] ? gpio_in : m_out_ch, m_out_dat, 2'b00};
    spi_frame(w, 16, r);
    chk({tag, " resp"}, 32'(r), 32'(exp));
    chk("R8 pad", 32'(r[1:0]), 32'h0);
    model_commit(w);
    chk_cfg(tag);
    chk("R10 idle", 32'(miso), 32'h0);
  endtask

  function automatic logic [15:0] man(input logic we, input logic [3:0] ch, input logic [6:0] s);
    return {4'b0001, we, ch, s};
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errs++;
      checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end

  initial begin
    logic [15:0] r;
    rst_n = 0; cs_n = 1; sclk = 0; mosi = 0; gpio_in = 4'h0; salt = '0;
    m_vld = 0; m_conv = 0; m_out_ch = 0; m_out_dat = 0; m_set = 0; m_cfg = 0;
    repeat (5) @(negedge clk);
    rst_n = 1;
    repeat (2) @(negedge clk);
    chk_cfg("R1");
    chk("R10 idle", 32'(miso), 32'h0);

    // R1: first two responses zero
    xfer("R1", man(1'b0, 4'd3, 7'h0));
    xfer("R1", man(1'b0, 4'd5, 7'h0));

    // R7/R3: full channel sweep
    for (int c = 0; c < 16; c++) xfer("R7", man(1'b0, 4'(c), 7'h7F));
    for (int c = 15; c >= 0; c -= 3) xfer("R3", man(1'b0, 4'(c), 7'h0));

    // R4: write-enable gating
    xfer("R4", man(1'b1, 4'd2, 7'b1100101));
    xfer("R4", man(1'b0, 4'd6, 7'b0011010));
    xfer("R4", man(1'b1, 4'd7, 7'b0001010));
    xfer("R4", man(1'b0, 4'd8, 7'b1111111));

    // R5: GPIO configuration
    xfer("R5", {4'b0100, 2'b00, 10'h05A});
    xfer("R5", {4'b0100, 2'b00, 10'h03C});

    // R11: range / power-down pins
    xfer("R11", man(1'b1, 4'd1, 7'b0000000));
    xfer("R11", {4'b0100, 2'b00, 10'h180});
    for (int g = 0; g < 16; g++) begin
      gpio_in = 4'(g);
      @(negedge clk);
      chk_cfg("R11");
    end
    xfer("R11", man(1'b1, 4'd4, 7'b1000000));
    for (int g = 0; g < 16; g += 5) begin
      gpio_in = 4'(g);
      @(negedge clk);
      chk_cfg("R11");
    end

    // R9: GPIO readback coinciding with a channel request
    gpio_in = 4'hB;
    xfer("R9", man(1'b1, 4'd9, 7'b0010011));
    xfer("R9", man(1'b0, 4'd10, 7'h0));
    gpio_in = 4'h6;
    xfer("R9", man(1'b1, 4'd11, 7'b0000011));
    xfer("R9", man(1'b0, 4'd12, 7'h0));

    // R12: other mode codes
    xfer("R12", 16'h0000);
    xfer("R12", 16'h2FFF);
    xfer("R12", man(1'b0, 4'd13, 7'h0));

    // R2: malformed frames discarded
    spi_frame(man(1'b1, 4'd14, 7'h7F), 15, r);
    repeat (2) @(negedge clk);
    chk_cfg("R2 short");
    spi_frame({4'b0100, 2'b00, 10'h3FF}, 17, r);
    repeat (2) @(negedge clk);
    chk_cfg("R2 long");
    xfer("R2", man(1'b0, 4'd0, 7'h0));
    xfer("R2", man(1'b0, 4'd15, 7'h0));

    // R8: new data pattern
    salt = 10'h2A5;
    for (int c = 0; c < 16; c += 2) xfer("R8", man(1'b0, 4'(c), 7'h0));

    // R6: clear while results in flight
    xfer("R6", {4'b0100, 2'b00, 10'h0FF});
    xfer("R6", man(1'b1, 4'd3, 7'b1110101));
    xfer("R6", {4'b0100, 2'b00, 10'h3FF});
    xfer("R6", man(1'b0, 4'd6, 7'h0));
    xfer("R6", man(1'b0, 4'd7, 7'h0));
    xfer("R6", man(1'b0, 4'd8, 7'h0));

    done = 1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule